// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block holds the interrupt enable register and produces the interrupt identification register and the single interrupt line of a 16550-style serial port. Each cycle it looks at five possible causes and picks the most urgent one that is enabled. The causes are receive line errors, a receive character timeout, received data waiting, the transmit holding register going empty, and a modem line change. It encodes the chosen cause into a four-bit identification code and registers an active-high interrupt from it.

A host reads and writes the block through a byte-wide register port with a 3-bit address. Address 1 is the enable register and address 2 is the identification register. The block also keeps a hidden flag that remembers a transmit-empty event. A host read of the identification register clears that flag. Writing the enable register while the holding register is empty sets the flag again. The shifter, the baud generator and the FIFO storage sit outside the block and supply only status inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register is 0, the interrupt output is low, the transmit-empty pending flag is clear, and the identification code reads 0x1 (nothing pending).
- R2: A write to address 1 stores only wr_data[3:0] in the enable register. A read of address 1 returns the stored bits with bits 7:4 zero.
- R3: When enable bit 2 is set and any bit of lsr_err is set, the code is 0x6. This line status source beats every other source.
- R4: When enable bit 0 is set and timeout_pend is high, the code is 0xC, unless a line status source is active. With enable bit 0 clear, the timeout source is ignored.
- R5: Enable bit 0 together with data_ready gives code 0x4 when fifo_en is low, or when rx_count >= trig_level. It yields only to the line status and timeout sources.
- R6: The transmit-empty pending flag is set the cycle after a thr_empty_evt pulse, or after an enable write while thr_empty is high. When enable bit 1 is set and the flag is set, the code is 0x2, unless a source with higher priority is active.
- R7: A read strobe at address 2 returns the code as it stands in that cycle. The pending flag is clear from the next cycle on, unless it is set again in that same cycle.
- R8: When enable bit 3 is set and any bit of msr_delta is set, the code is 0x0. This is the lowest priority.
- R9: A read of address 2 returns bits 7:6 as 2'b11 when fifo_en is high and 2'b00 otherwise, bits 5:4 as zero, and bits 3:0 as the code.
- R10: irq equals, one clock later, whether the code was other than 0x1.
- R11: A read of any address other than 1 or 2 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_addr (combinational) |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| data_ready | input | 1 | Receive data present |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_level | input | CNT_W | Receive trigger level |
| timeout_pend | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Holding register currently empty |
| thr_empty_evt | input | 1 | Pulse when the holding register becomes empty |
| msr_delta | input | 4 | Modem status change bits |
| irq | output | 1 | Registered interrupt, active high |

## Verification
The assertions check on every cycle the properties that hold at all times. Line errors always win. No receive-side code appears while enable bit 0 is clear. The upper nibble of an enable read is zero. The identification read carries the FIFO flag and zero bits 5:4. The interrupt lags the code by exactly one clock. An identification read with no set request leaves the flag clear. Only the bench's scenarios can show the full priority order when several sources are active at once. They also show the trigger-level comparison at its boundary and the re-arming of the pending flag through an enable write. A reference model, compared against the block on every clock, covers long stretches of random input.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC = 5;

    // source index order is the priority order, 0 highest
    localparam int SRC_LSTAT   = 0;
    localparam int SRC_TIMEOUT = 1;
    localparam int SRC_RXDATA  = 2;
    localparam int SRC_THRE    = 3;
    localparam int SRC_MODEM   = 4;

    localparam logic [3:0] ID_NONE = 4'h1;

    typedef struct packed {
        logic [3:0] ier;
        logic       thr_pend;
        logic       irq;
    } irq_state_t;

    function automatic logic [3:0] id_of(input int idx);
        case (idx)
            SRC_LSTAT:   id_of = 4'h6;
            SRC_TIMEOUT: id_of = 4'hC;
            SRC_RXDATA:  id_of = 4'h4;
            SRC_THRE:    id_of = 4'h2;
            default:     id_of = 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             timeout_pend,
    input  logic             thr_pend,
    input  logic [3:0]       msr_delta,
    output logic [NSRC-1:0]  req
);

    logic rx_level_met;

    always_comb begin
        rx_level_met     = !fifo_en || (rx_count >= trig_level);
        req              = '0;
        req[SRC_LSTAT]   = ier[2] && (|lsr_err);
        req[SRC_TIMEOUT] = ier[0] && timeout_pend;
        req[SRC_RXDATA]  = ier[0] && data_ready && rx_level_met;
        req[SRC_THRE]    = ier[1] && thr_pend;
        req[SRC_MODEM]   = ier[3] && (|msr_delta);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    output logic [3:0]   code
);

    logic [N:0]   above;
    logic [N-1:0] grant;

    assign above[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]   = req[i] && !above[i];
            assign above[i+1] = above[i] || req[i];
        end
    endgenerate

    always_comb begin
        code = above[N] ? 4'h0 : ID_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = code | id_of(i);
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int         CNT_W    = 5,
    parameter logic [2:0] ADDR_IER = 3'd1,
    parameter logic [2:0] ADDR_IIR = 3'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             timeout_pend,
    input  logic             thr_empty,
    input  logic             thr_empty_evt,
    input  logic [3:0]       msr_delta,
    output logic             irq
);

    irq_state_t      st_d, st_q;
    logic [NSRC-1:0] req;
    logic [3:0]      iir_code;
    logic            ier_wr, iir_rd;

    uart_irq_src #(.CNT_W(CNT_W)) u_src (
        .ier          (st_q.ier),
        .lsr_err      (lsr_err),
        .data_ready   (data_ready),
        .fifo_en      (fifo_en),
        .rx_count     (rx_count),
        .trig_level   (trig_level),
        .timeout_pend (timeout_pend),
        .thr_pend     (st_q.thr_pend),
        .msr_delta    (msr_delta),
        .req          (req)
    );

    uart_irq_prio #(.N(NSRC)) u_prio (
        .req  (req),
        .code (iir_code)
    );

    always_comb begin
        ier_wr = wr_en && (reg_addr == ADDR_IER);
        iir_rd = rd_en && (reg_addr == ADDR_IIR);

        st_d = st_q;
        if (ier_wr) st_d.ier = wr_data[3:0];
        if (iir_rd) st_d.thr_pend = 1'b0;
        if (thr_empty_evt || (ier_wr && thr_empty)) st_d.thr_pend = 1'b1;
        st_d.irq = (iir_code != ID_NONE);

        if (reg_addr == ADDR_IER)
            rd_data = {4'b0000, st_q.ier};
        else if (reg_addr == ADDR_IIR)
            rd_data = {{2{fifo_en}}, 2'b00, iir_code};
        else
            rd_data = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] reg_addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [3:0] ier,
    input logic [3:0] lsr_err,
    input logic       fifo_en,
    input logic       thr_empty_evt,
    input logic       thr_pend,
    input logic [3:0] code,
    input logic       irq,
    input logic [7:0] rd_data
);

    AST_LSTAT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && (|lsr_err)) |-> (code == 4'h6));  // R3

    AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ier[0] |-> (code != 4'hC && code != 4'h4));  // R4

    AST_IER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd1) |-> (rd_data[7:4] == 4'h0));  // R2

    AST_IIR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd2) |-> (rd_data[5:4] == 2'b00 && rd_data[7:6] == {2{fifo_en}}));  // R9

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(code != 4'h1)));  // R10

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == 3'd2 && !thr_empty_evt && !wr_en) |=> !thr_pend);  // R7

endmodule

bind uart_irq_ident uart_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .ier           (st_q.ier),
    .lsr_err       (lsr_err),
    .fifo_en       (fifo_en),
    .thr_empty_evt (thr_empty_evt),
    .thr_pend      (st_q.thr_pend),
    .code          (iir_code),
    .irq           (irq),
    .rd_data       (rd_data)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;
    logic [3:0]       lsr_err = '0;
    logic             data_ready = 1'b0, fifo_en = 1'b0;
    logic [CNT_W-1:0] rx_count = '0, trig_level = '0;
    logic             timeout_pend = 1'b0, thr_empty = 1'b0, thr_empty_evt = 1'b0;
    logic [3:0]       msr_delta = '0;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [3:0] m_ier;
    logic       m_pend;
    logic       m_irq;

    always #2 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .lsr_err(lsr_err), .data_ready(data_ready),
        .fifo_en(fifo_en), .rx_count(rx_count), .trig_level(trig_level),
        .timeout_pend(timeout_pend), .thr_empty(thr_empty), .thr_empty_evt(thr_empty_evt),
        .msr_delta(msr_delta), .irq(irq)
    );

    function automatic logic [3:0] exp_code();
        if (m_ier[2] && lsr_err != 0)                                          return 4'h6;
        if (m_ier[0] && timeout_pend)                                           return 4'hC;
        if (m_ier[0] && data_ready && (!fifo_en || int'(rx_count) >= int'(trig_level))) return 4'h4;
        if (m_ier[1] && m_pend)                                                 return 4'h2;
        if (m_ier[3] && msr_delta != 0)                                         return 4'h0;
        return 4'h1;
    endfunction

    function automatic logic [7:0] exp_rd();
        if (reg_addr == 3'd1) return {4'h0, m_ier};
        if (reg_addr == 3'd2) return {fifo_en ? 2'b11 : 2'b00, 2'b00, exp_code()};
        return 8'h00;
    endfunction

    task automatic tick(input string tag);
        logic [3:0] c;
        logic       p;
        #1;
        n_cmp++;
        if (rd_data !== exp_rd()) begin
            n_bad++;
            $display("FAIL %s rd_data addr=%0d actual=%h expected=%h", tag, reg_addr, rd_data, exp_rd());
        end
        n_cmp++;
        if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
        end
        @(posedge clk);
        c = exp_code();
        p = m_pend;
        if (rd_en && reg_addr == 3'd2) p = 1'b0;
        if (thr_empty_evt || (wr_en && reg_addr == 3'd1 && thr_empty)) p = 1'b1;
        m_pend = p;
        m_irq  = (c != 4'h1);
        if (wr_en && reg_addr == 3'd1) m_ier = wr_data[3:0];
        @(negedge clk);
    endtask

    task automatic ier_write(input logic [7:0] v, input string tag);
        reg_addr = 3'd1; wr_en = 1'b1; wr_data = v;
        tick(tag);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        m_ier = '0; m_pend = 1'b0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        reg_addr = 3'd2; tick("R1");
        reg_addr = 3'd1; tick("R1");
        // R2: only low nibble of enable stored
        ier_write(8'hFF, "R2");
        reg_addr = 3'd1; tick("R2");
        // R11: unmapped addresses
        reg_addr = 3'd5; tick("R11");
        reg_addr = 3'd0; tick("R11");
        // R3: line status beats everything
        reg_addr = 3'd2; lsr_err = 4'b0100; timeout_pend = 1'b1; data_ready = 1'b1;
        msr_delta = 4'b0001; tick("R3"); tick("R3");
        // R4: timeout next
        lsr_err = 4'b0000; tick("R4"); tick("R4");
        // R5: trigger level boundary with FIFO on
        timeout_pend = 1'b0; fifo_en = 1'b1; trig_level = 5'd4; rx_count = 5'd3;
        tick("R5"); tick("R5");
        rx_count = 5'd4; tick("R5"); tick("R5");
        fifo_en = 1'b0; rx_count = 5'd0; tick("R9"); tick("R5");
        // R4: timeout ignored without enable bit 0
        ier_write(8'h0C, "R4");
        reg_addr = 3'd2; timeout_pend = 1'b1; tick("R4"); tick("R8");
        // R8: modem source lowest
        tick("R8");
        // R6: enable write with holding register empty arms the flag
        msr_delta = 4'b0000; timeout_pend = 1'b0; data_ready = 1'b0; thr_empty = 1'b1;
        ier_write(8'h02, "R6");
        reg_addr = 3'd2; tick("R6"); tick("R6");
        // R7: identification read clears flag after read
        rd_en = 1'b1; tick("R7"); rd_en = 1'b0;
        tick("R7"); tick("R7");
        // R6: event pulse re-arms
        thr_empty_evt = 1'b1; tick("R6"); thr_empty_evt = 1'b0;
        tick("R6"); tick("R6");
        // R8: modem loses to transmit empty
        ier_write(8'h0A, "R8");
        reg_addr = 3'd2; msr_delta = 4'b1000; tick("R8");
        rd_en = 1'b1; tick("R8"); rd_en = 1'b0; tick("R8"); tick("R8");
        // R10: random sweep
        for (int i = 0; i < 3000; i++) begin
            reg_addr      = 3'($urandom_range(0, 3));
            wr_en         = ($urandom_range(0, 7) == 0);
            rd_en         = !wr_en && ($urandom_range(0, 3) == 0);
            wr_data       = 8'($urandom);
            lsr_err       = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            data_ready    = 1'($urandom);
            fifo_en       = 1'($urandom);
            rx_count      = 5'($urandom_range(0, 16));
            trig_level    = 5'($urandom_range(1, 14));
            timeout_pend  = ($urandom_range(0, 3) == 0);
            thr_empty     = 1'($urandom);
            thr_empty_evt = ($urandom_range(0, 7) == 0);
            msr_delta     = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
            tick("R10");
        end
        summary();
    end

endmodule